// File: doc/BRIEF.md
# Watchdog Reset Timer with Final Divide-by-Eight Stage

This block is a watchdog that guards a processor against runaway software. It counts pulses from an external periodic tick source, one clock wide, that comes from a free-running upstream divider. When eight ticks have been counted since the watchdog stage was last cleared, the block issues an internal system reset request. It also pulls the external reset pin low for a fixed number of clock cycles, so that devices on the board are reset together with the processor.

Software keeps the watchdog quiet by writing a zero in data bit 0 to a fixed service address. That write clears only the divide-by-eight stage and leaves the upstream tick source alone. Because the phase of the next tick is unknown, the real timeout falls between seven and eight tick periods after a service. Software must therefore service within seven tick periods. A configuration enable, which comes up set after reset, can switch the watchdog off. While the enable is low, the stage is held at zero.

Top module: `cop_wdog`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, `sys_rst_req_o` is 0, `ext_rst_no` is 1 and the divide stage is zero.
- R2: While enabled, the stage counts cycles with `rti_tick_i`=1. The eighth counted tick makes `sys_rst_req_o` 1 for exactly one cycle, in the cycle after the clock edge that samples that tick.
- R3: After a timeout the stage restarts from zero, so the next timeout needs eight more ticks.
- R4: A service write clears the stage, so the next timeout needs eight further ticks. A service write is `bus_we_i`=1, `bus_addr_i`=SVC_ADDR (default 16'hFFFF) and `bus_wdata_i[0]`=0. This holds whatever the phase of the service relative to the ticks.
- R5: A write to SVC_ADDR with `bus_wdata_i[0]`=1 has no effect on the stage or the outputs.
- R6: A write with `bus_wdata_i[0]`=0 to any address other than SVC_ADDR has no effect on the stage or the outputs.
- R7: When a service write and a tick occur in the same cycle, the service wins and the tick is not counted.
- R8: While `cop_en_i`=0 the stage is held at zero and no timeout occurs. After re-enabling, eight new ticks are needed.
- R9: `ext_rst_no` goes low in the same cycle that `sys_rst_req_o` rises. It stays low for exactly HOLD_CYCLES cycles (default 64), then returns high, and it never goes low without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rti_tick_i | input | 1 | One-cycle tick from the upstream periodic divider |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 16 | Bus write address |
| bus_wdata_i | input | 8 | Bus write data; only bit 0 matters |
| cop_en_i | input | 1 | Configuration enable, 1 = watchdog active |
| sys_rst_req_o | output | 1 | One-cycle internal reset request |
| ext_rst_no | output | 1 | Active-low drive of the external reset pin |

## Verification
The assertions check four things on every cycle. A request lasts a single cycle. The pin is low whenever a request is present and falls only together with one. The low interval ends after exactly HOLD_CYCLES cycles. A cycle that carries a service write or has the enable low is never followed by a request. Only the bench scenarios can show that the request comes on exactly the eighth tick. They also show that the count restarts after a timeout and after a service taken at different tick phases, that rejected writes leave the count intact, and that service beats a coincident tick.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int unsigned COP_ADDR_W = 16;
  localparam int unsigned COP_DATA_W = 8;
  typedef logic [COP_ADDR_W-1:0] cop_addr_t;
  typedef logic [COP_DATA_W-1:0] cop_data_t;
  typedef struct packed {
    logic      we;
    cop_addr_t addr;
    cop_data_t data;
  } cop_bus_wr_t;
endpackage

// File: rtl/cop_svc_dec.sv
module cop_svc_dec
  import cop_pkg::*;
#(
  parameter cop_addr_t SVC_ADDR = 16'hFFFF
) (
  input  cop_bus_wr_t wr_i,
  output logic        svc_o
);
  logic unused_wdata;
  assign unused_wdata = ^wr_i.data[COP_DATA_W-1:1];
  // only a zero in bit 0 counts as service
  assign svc_o = wr_i.we && (wr_i.addr == SVC_ADDR) && !wr_i.data[0];
endmodule

// File: rtl/cop_divstage.sv
module cop_divstage #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic fire_o
);
  logic [STAGES-1:0] cnt_q;
  logic [STAGES:0]   carry;

  assign carry[0] = tick_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_bit
    assign carry[i+1] = carry[i] & cnt_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q[i] <= 1'b0;
      else if (clr_i)    cnt_q[i] <= 1'b0;
      else if (carry[i]) cnt_q[i] <= ~cnt_q[i];
    end
  end

  // terminal carry wraps the stage to zero on the same edge
  assign fire_o = carry[STAGES] & ~clr_i;
endmodule

// File: rtl/cop_rst_stretch.sv
module cop_rst_stretch #(
  parameter int unsigned HOLD_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic req_o,
  output logic pin_no
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  logic          req_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      req_q <= fire_i;
      if (fire_i)            hold_q <= HW'(HOLD_CYCLES);
      else if (hold_q != '0) hold_q <= hold_q - 1'b1;
    end
  end

  assign req_o  = req_q;
  assign pin_no = (hold_q == '0);
endmodule

// File: rtl/cop_wdog.sv
module cop_wdog
  import cop_pkg::*;
#(
  parameter int unsigned DIV_STAGES  = 3,
  parameter int unsigned HOLD_CYCLES = 64,
  parameter cop_addr_t   SVC_ADDR    = 16'hFFFF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rti_tick_i,
  input  logic                  bus_we_i,
  input  logic [COP_ADDR_W-1:0] bus_addr_i,
  input  logic [COP_DATA_W-1:0] bus_wdata_i,
  input  logic                  cop_en_i,
  output logic                  sys_rst_req_o,
  output logic                  ext_rst_no
);
  cop_bus_wr_t wr;
  logic        svc_hit;
  logic        stage_clr;
  logic        tmo_fire;

  assign wr.we   = bus_we_i;
  assign wr.addr = bus_addr_i;
  assign wr.data = bus_wdata_i;

  cop_svc_dec #(.SVC_ADDR(SVC_ADDR)) u_dec (
    .wr_i (wr),
    .svc_o(svc_hit)
  );

  assign stage_clr = svc_hit | ~cop_en_i;

  cop_divstage #(.STAGES(DIV_STAGES)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(rti_tick_i),
    .clr_i (stage_clr),
    .fire_o(tmo_fire)
  );

  cop_rst_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(tmo_fire),
    .req_o (sys_rst_req_o),
    .pin_no(ext_rst_no)
  );
endmodule

// File: rtl/cop_wdog_chk.sv
module cop_wdog_chk
  import cop_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 64,
  parameter cop_addr_t   SVC_ADDR    = 16'hFFFF
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_we_i,
  input logic [COP_ADDR_W-1:0] bus_addr_i,
  input logic [COP_DATA_W-1:0] bus_wdata_i,
  input logic                  cop_en_i,
  input logic                  sys_rst_req_o,
  input logic                  ext_rst_no
);
  localparam int unsigned LW = $clog2(HOLD_CYCLES + 1) + 1;

  logic [LW-1:0] low_run;
  logic          svc_seen;

  assign svc_seen = bus_we_i && (bus_addr_i == SVC_ADDR) && (bus_wdata_i[0] == 1'b0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            low_run <= '0;
    else if (sys_rst_req_o) low_run <= LW'(1);
    else if (ext_rst_no)    low_run <= '0;
    else                    low_run <= low_run + 1'b1;
  end

  // R2
  req_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> !sys_rst_req_o);

  // R9
  pin_low_with_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> !ext_rst_no);

  // R9
  pin_fall_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_rst_no) |-> sys_rst_req_o);

  // R9
  pin_hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_rst_no) |-> (low_run == LW'(HOLD_CYCLES)));

  // R8
  disabled_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cop_en_i |=> !sys_rst_req_o);

  // R4
  service_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_seen |=> !sys_rst_req_o);
endmodule

bind cop_wdog cop_wdog_chk #(
  .HOLD_CYCLES(HOLD_CYCLES),
  .SVC_ADDR   (SVC_ADDR)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .cop_en_i     (cop_en_i),
  .sys_rst_req_o(sys_rst_req_o),
  .ext_rst_no   (ext_rst_no)
);

// File: tb/cop_wdog_tb_top.sv
module cop_wdog_tb_top;
  localparam int HOLD = 64;
  localparam int DIV  = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rti_tick_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [15:0] bus_addr_i = 16'h0;
  logic [7:0]  bus_wdata_i = 8'h0;
  logic        cop_en_i = 1'b1;
  logic        sys_rst_req_o;
  logic        ext_rst_no;

  int    vectors = 0;
  int    miscompares = 0;
  int    cyc = 0;
  int    pulses = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference state
  int ref_cnt = 0;
  int ref_hold = 0;
  bit ref_req = 1'b0;

  always #10 clk_i = ~clk_i;

  cop_wdog #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rti_tick_i   (rti_tick_i),
    .bus_we_i     (bus_we_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .cop_en_i     (cop_en_i),
    .sys_rst_req_o(sys_rst_req_o),
    .ext_rst_no   (ext_rst_no)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog (%s): actual cycle %0d, expected end before 150000", tag, cyc);
      finish_run();
    end
  end

  task automatic compare();
    vectors++;
    if (sys_rst_req_o !== ref_req) begin
      miscompares++;
      $display("FAIL %s: sys_rst_req_o actual %b expected %b at cycle %0d", tag, sys_rst_req_o, ref_req, cyc);
    end
    vectors++;
    if (ext_rst_no !== (ref_hold == 0)) begin
      miscompares++;
      $display("FAIL %s: ext_rst_no actual %b expected %b at cycle %0d", tag, ext_rst_no, ref_hold == 0, cyc);
    end
    if (sys_rst_req_o === 1'b1) pulses++;
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic step(bit tk, bit we, logic [15:0] a, logic [7:0] d);
    bit svc, fire;
    rti_tick_i  = tk;
    bus_we_i    = we;
    bus_addr_i  = a;
    bus_wdata_i = d;
    @(posedge clk_i);
    svc  = we && (a == 16'hFFFF) && (d[0] == 1'b0);
    fire = 1'b0;
    if (!cop_en_i || svc) ref_cnt = 0;
    else if (tk) begin
      if (ref_cnt == DIV - 1) begin fire = 1'b1; ref_cnt = 0; end
      else ref_cnt = ref_cnt + 1;
    end
    ref_req = fire;
    if (fire) ref_hold = HOLD;
    else if (ref_hold > 0) ref_hold = ref_hold - 1;
    @(negedge clk_i);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0, 8'h0);
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      idle(gap);
      step(1'b1, 1'b0, 16'h0, 8'h0);
    end
  endtask

  task automatic service();
    step(1'b0, 1'b1, 16'hFFFF, 8'hFE);
  endtask

  task automatic check_pulses(int exp);
    vectors++;
    if (pulses != exp) begin
      miscompares++;
      $display("FAIL %s: request pulses actual %0d expected %0d", tag, pulses, exp);
    end
    pulses = 0;
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk_i);
    compare();
    rst_ni = 1'b1;
    idle(3);
    check_pulses(0);

    // R2: eighth tick fires, seventh does not
    tag = "R2";
    ticks(7, 4);
    idle(10);
    check_pulses(0);
    ticks(1, 4);
    idle(HOLD + 5);
    check_pulses(1);

    // R3: restart after timeout
    tag = "R3";
    ticks(7, 3);
    check_pulses(0);
    ticks(1, 3);
    idle(HOLD + 5);
    check_pulses(1);

    // R4: service at different phases between ticks
    tag = "R4";
    for (int ph = 0; ph < 5; ph++) begin
      ticks(5, 6);
      idle(ph);
      service();
      ticks(7, 6);
      check_pulses(0);
      ticks(1, 6);
      idle(HOLD + 2);
      check_pulses(1);
    end

    // R5: bit 0 set at service address ignored
    tag = "R5";
    ticks(6, 3);
    step(1'b0, 1'b1, 16'hFFFF, 8'h01);
    step(1'b0, 1'b1, 16'hFFFF, 8'hFF);
    ticks(2, 3);
    idle(HOLD + 2);
    check_pulses(1);

    // R6: other address ignored
    tag = "R6";
    ticks(6, 3);
    step(1'b0, 1'b1, 16'hFFFE, 8'h00);
    step(1'b0, 1'b1, 16'h7FFF, 8'h00);
    step(1'b0, 1'b0, 16'hFFFF, 8'h00);
    ticks(2, 3);
    idle(HOLD + 2);
    check_pulses(1);

    // R7: service beats coincident tick
    tag = "R7";
    ticks(7, 3);
    step(1'b1, 1'b1, 16'hFFFF, 8'h00);
    ticks(7, 3);
    check_pulses(0);
    ticks(1, 3);
    idle(HOLD + 2);
    check_pulses(1);

    // R8: disable holds stage clear
    tag = "R8";
    ticks(6, 3);
    cop_en_i = 1'b0;
    ticks(20, 2);
    check_pulses(0);
    cop_en_i = 1'b1;
    ticks(7, 2);
    check_pulses(0);
    ticks(1, 2);
    idle(HOLD + 2);
    check_pulses(1);

    // R9: hold length, fire during hold reloads it
    tag = "R9";
    ticks(8, 0);
    idle(HOLD / 2);
    ticks(8, 0);
    idle(HOLD + 4);
    check_pulses(2);

    // R1: asynchronous reset mid-count and mid-hold
    tag = "R1";
    ticks(8, 1);
    idle(3);
    rst_ni = 1'b0;
    ref_cnt = 0; ref_hold = 0; ref_req = 1'b0;
    #1;
    compare();
    @(negedge clk_i);
    rst_ni = 1'b1;
    compare();
    ticks(7, 1);
    idle(3);
    pulses = 0;
    ticks(1, 1);
    idle(HOLD + 2);
    check_pulses(1);

    finish_run();
  end
endmodule